// File: doc/BRIEF.md
# A/D Conversion-Start Pacer Selector

This block decides when an A/D converter starts a conversion, and signals it with a conversion-start pulse one clock wide. Software picks one of three sources through a single byte-wide control/status register. The first source is a tick from an on-chip pacer counter. The second is an edge on an external pacer pin, with the edge direction selectable. The third is software polling, in which the block never issues a start.

When the on-chip tick is the source, a gate pin decides whether ticks get through. There are three ways to use it. A force bit lets every tick through and ignores the pin. In level mode, ticks pass only while the pin is at its active level. In edge mode, an active edge on the pin sets a latch that stays set until software clears it, and ticks pass while the latch is set. A polarity bit picks whether the gate is active high and rising, or active low and falling. The external pacer pin and the gate pin are asynchronous and pass through a synchronizer. The on-chip tick is already synchronous and is used directly.

No data moves through this block, so it has no valid/ready interface and no back-pressure. The conversion-start output is a bare pulse that the consumer must accept in the cycle it is high. All the other pins are plain control and status signals.

Top module: `pacer_start_ctrl`

## Requirements
- R1: After reset the register reads 0x00, which selects software polling, and no conversion-start pulse is produced.
- R2: With bit 1 at 0 (software polling), no pulse is produced, whatever the value of bit 0, the tick or either pin.
- R3: With bits[1:0] = 11 (internal), each tick that is high on a clock edge while the gate is open gives exactly one pulse in the cycle after that edge.
- R4: With bits[1:0] = 10 (external), each rising edge of the external pin gives one pulse when bit 2 = 0, and each falling edge gives one when bit 2 = 1. The pulse appears three clock edges after the pin changes. The opposite edge gives no pulse.
- R5: The external pin has no effect in internal mode, and the tick has no effect in external mode.
- R6: In level mode (bit 3 = 0, bit 4 = 0), ticks pass only while the synchronized gate pin is active: high when bit 5 = 0, low when bit 5 = 1.
- R7: In edge mode (bit 3 = 0, bit 4 = 1) in internal mode, an active gate edge (rising when bit 5 = 0, falling when bit 5 = 1) sets the gate latch. Ticks then pass until the latch is cleared, even after the pin returns to its idle level.
- R8: A register write with bit 6 = 0 clears the gate latch, and a write with bit 6 = 1 leaves it unchanged. If a latch-setting edge and a clearing write happen on the same clock edge, the latch ends up set.
- R9: A read returns bits[5:0] as written and bit 7 as 0. Bit 6 reads the latch state in edge mode, and in level mode it reads whether the gate is active.
- R10: With bit 3 = 1 in internal mode, every tick passes whatever the gate pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| int_tick | input | 1 | Tick from the on-chip pacer counter, synchronous |
| ext_pacer_pin | input | 1 | External pacer pin, asynchronous |
| gate_pin | input | 1 | Gate pin for the on-chip pacer, asynchronous |
| conv_start | output | 1 | Conversion-start pulse |

## Verification
Assertions check several properties on every cycle. No pulse follows a cycle in software mode. In internal mode, no pulse appears without a tick, and a forced gate always lets a tick through. In external mode, no pulse appears without a qualifying synchronized edge. The gate latch never drops unless a clearing write arrives, and never rises without an armed active edge. The bench scenarios cover what those properties cannot: the exact three-cycle delay after an external pin edge, the choice of edge direction, the level-mode gating for both polarities, the latch persisting after the pin falls, the race between a latch-setting edge and a clearing write, and the meaning of status bit 6.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    SRC_POLL0 = 2'b00,
    SRC_POLL1 = 2'b01,
    SRC_EXT   = 2'b10,
    SRC_INT   = 2'b11
  } pacer_src_e;

  // stored control bits, MSB first: bit5 .. bit0
  typedef struct packed {
    logic       gate_low;
    logic       gate_edge;
    logic       gate_force;
    logic       ext_fall;
    pacer_src_e src;
  } pacer_ctrl_t;

  localparam int CTRL_W = $bits(pacer_ctrl_t);
endpackage

// File: rtl/pacer_sync.sv
module pacer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic lvl,
  output logic lvl_d
);
  localparam int SHW = STAGES + 1;
  logic [SHW-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SHW-2:0], pin_async};
  end

  assign lvl   = sh_q[STAGES-1];
  assign lvl_d = sh_q[STAGES];
endmodule

// File: rtl/pacer_gate.sv
module pacer_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_pin,
  input  logic int_sel,
  input  logic force_on,
  input  logic edge_mode,
  input  logic low_active,
  input  logic clr,
  output logic gate_open,
  output logic gate_status
);
  logic lvl, lvl_d, rise, fall, act_edge, act_lvl, armed, latch_q;

  pacer_sync #(.STAGES(STAGES)) u_gsync (
    .clk(clk), .rst_n(rst_n), .pin_async(gate_pin), .lvl(lvl), .lvl_d(lvl_d)
  );

  assign rise     = lvl & ~lvl_d;
  assign fall     = ~lvl & lvl_d;
  assign act_edge = low_active ? fall : rise;
  assign act_lvl  = lvl ^ low_active;
  assign armed    = int_sel & edge_mode & ~force_on;

  // set wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   latch_q <= 1'b0;
    else if (armed && act_edge)   latch_q <= 1'b1;
    else if (clr)                 latch_q <= 1'b0;
  end

  assign gate_status = edge_mode ? latch_q : act_lvl;
  assign gate_open   = force_on | gate_status;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr) |=> latch_q); // R8
  AST_LATCH_ARMED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_q && !(armed && act_edge)) |=> !latch_q); // R7
endmodule

// File: rtl/pacer_start_ctrl.sv
module pacer_start_ctrl
  import pacer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             int_tick,
  input  logic             ext_pacer_pin,
  input  logic             gate_pin,
  output logic             conv_start
);
  localparam int STAT_BIT = CTRL_W;

  pacer_ctrl_t ctrl_q;
  logic ext_lvl, ext_lvl_d, ext_edge, gate_open, gate_status, clr, sel_int, sel_ext, start_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (reg_wr) ctrl_q <= pacer_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  assign clr     = reg_wr & ~reg_wdata[STAT_BIT];
  assign sel_int = (ctrl_q.src == SRC_INT);
  assign sel_ext = (ctrl_q.src == SRC_EXT);

  pacer_sync #(.STAGES(SYNC_STAGES)) u_esync (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_pacer_pin), .lvl(ext_lvl), .lvl_d(ext_lvl_d)
  );

  // edge chosen on raw synced value: a polarity change cannot fake an edge
  assign ext_edge = ctrl_q.ext_fall ? (~ext_lvl & ext_lvl_d) : (ext_lvl & ~ext_lvl_d);

  pacer_gate #(.STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_pin(gate_pin), .int_sel(sel_int),
    .force_on(ctrl_q.gate_force), .edge_mode(ctrl_q.gate_edge),
    .low_active(ctrl_q.gate_low), .clr(clr),
    .gate_open(gate_open), .gate_status(gate_status)
  );

  assign start_d = (sel_int & int_tick & gate_open) | (sel_ext & ext_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_start <= 1'b0;
    else        conv_start <= start_d;
  end

  always_comb begin
    reg_rdata                = '0;
    reg_rdata[CTRL_W-1:0]    = ctrl_q;
    reg_rdata[STAT_BIT]      = gate_status;
  end

  AST_POLL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.src[1]) |=> !conv_start); // R2
  AST_INT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_int && !int_tick) |=> !conv_start); // R3
  AST_EXT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ext && !ext_edge) |=> !conv_start); // R4
  AST_FORCE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_int && ctrl_q.gate_force && int_tick) |=> conv_start); // R10
endmodule

// File: tb/pacer_start_ctrl_bench.sv
module pacer_start_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, int_tick = 1'b0;
  logic ext_pacer_pin = 1'b0, gate_pin = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic conv_start;

  int cyc = 0, checks = 0, fails = 0;
  bit running = 0, done = 0;
  string cur_req = "R1";
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pacer_start_ctrl u_pacer_start_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_tick(int_tick), .ext_pacer_pin(ext_pacer_pin),
    .gate_pin(gate_pin), .conv_start(conv_start)
  );

  // monitor: compare each cycle against scoreboard
  always @(negedge clk) begin
    if (running) begin
      bit exp_p;
      exp_p = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (exp_p) void'(exp_q.pop_front());
      checks++;
      if (conv_start !== exp_p) begin
        fails++;
        $display("FAIL %s: conv_start at cycle %0d = %b, expected %b", cur_req, cyc, conv_start, exp_p);
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic wr_reg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] e, input string r);
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s: reg_rdata = %h, expected %h", r, reg_rdata, e);
    end
  endtask

  task automatic tick(input bit pass, input string r);
    cur_req = r;
    int_tick = 1'b1;
    if (pass) exp_q.push_back(cyc + 1);
    @(negedge clk);
    int_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ext_set(input logic v, input bit pass, input string r);
    cur_req = r;
    ext_pacer_pin = v;
    if (pass) exp_q.push_back(cyc + 3);
    repeat (4) @(negedge clk);
  endtask

  task automatic gate_set(input logic v);
    gate_pin = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;
    // R1 reset state
    chk_rd(8'h00, "R1");
    tick(0, "R1");
    ext_set(1'b1, 0, "R1");
    ext_set(1'b0, 0, "R1");
    // R2 polling ignores bit0 and all inputs
    wr_reg(8'h01);
    tick(0, "R2");
    ext_set(1'b1, 0, "R2");
    ext_set(1'b0, 0, "R2");
    // R3 / R10 internal forced, R5 ext pin ignored
    wr_reg(8'h0B);
    tick(1, "R3");
    tick(1, "R10");
    ext_set(1'b1, 0, "R5");
    ext_set(1'b0, 0, "R5");
    // R4 external rising
    wr_reg(8'h02);
    ext_set(1'b1, 1, "R4");
    ext_set(1'b0, 0, "R4");
    tick(0, "R5");
    // R4 external falling
    wr_reg(8'h06);
    ext_set(1'b1, 0, "R4");
    ext_set(1'b0, 1, "R4");
    // R6 level gate, high active
    wr_reg(8'h03);
    gate_set(1'b0);
    tick(0, "R6");
    chk_rd(8'h03, "R9");
    gate_set(1'b1);
    tick(1, "R6");
    chk_rd(8'h43, "R9");
    // R6 level gate, low active
    wr_reg(8'h23);
    tick(0, "R6");
    chk_rd(8'h23, "R9");
    gate_set(1'b0);
    tick(1, "R6");
    chk_rd(8'h63, "R9");
    // R7 edge latch, rising
    wr_reg(8'h13);
    tick(0, "R7");
    chk_rd(8'h13, "R7");
    gate_set(1'b1);
    chk_rd(8'h53, "R7");
    tick(1, "R7");
    gate_set(1'b0);
    tick(1, "R7");
    // R8 write with bit6=1 keeps latch, bit6=0 clears
    wr_reg(8'h53);
    chk_rd(8'h53, "R8");
    tick(1, "R8");
    wr_reg(8'h13);
    chk_rd(8'h13, "R8");
    tick(0, "R8");
    // R8 edge and clear on the same clock edge: latch set
    gate_pin = 1'b1;
    repeat (2) @(negedge clk);
    wr_reg(8'h13);
    @(negedge clk);
    chk_rd(8'h53, "R8");
    tick(1, "R8");
    // R9 bit7 reads 0, bit6 write ignored; R10 force with gate inactive
    wr_reg(8'hAF);
    chk_rd(8'h2F, "R9");
    tick(1, "R10");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3: %0d expected pulses never seen, expected 0", exp_q.size());
    end
    running = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule